// File: doc/BRIEF.md
# Per-CPU Interrupt Interface with Inter-Processor Signalling

This block is the part of a multiprocessor interrupt controller that belongs to one core. One copy sits beside each CPU. It combines three kinds of request into one interrupt line:

- sixteen software interrupts, which are latched inside the block;
- sixteen private level-sensitive lines that belong to this core;
- a parameterised number of shared level-sensitive requests, which an external router has already steered to this core.

Each interrupt ID has its own enable bit and its own active bit. Software reads a ready register to acknowledge the most urgent request and later writes the ID back to end its servicing.

Enable, disable and completion all work by writing an interrupt ID as a plain value into a dedicated register. None of them takes a bitmask. A highest-pending register lets the handler loop until no work remains without acknowledging anything. A signal register sends a software interrupt number to any set of cores over a broadcast bus. Every interface, this one included, watches that bus and latches the software interrupt when its own bit in the mask is set. Among candidates, the lowest ID always wins.

Top module: `percpu_intc_if`

## Requirements
- R1: After reset `irq_out` is 0, the interface is disabled, every enable and active bit is clear, no software interrupt is latched, and reads of the ready register (offset 0x6C) return 1023.
- R2: IDs 0 to 15 are software interrupts, ID 16+i is `priv_req[i]` and ID 32+j is `shared_req[j]`; all three kinds take part in one common arbitration.
- R3: Writing an ID in `bus_wdata[9:0]` to offset 0xA0 enables it and writing it to 0xA4 disables it; an ID of 32+NUM_SHARED or more is ignored and does not alias onto a lower ID.
- R4: Bit 0 of offset 0x00 enables the interface and reads back in bit 0; while it is 0, `irq_out` stays low and the ready register returns 1023.
- R5: `irq_out` is 1 exactly one cycle after some ID is at the same time pending, enabled and not active while the interface is enabled.
- R6: A read of offset 0x6C returns, in the next cycle, the lowest such candidate ID in `bus_rdata[9:0]` with the upper bits zero, and marks that ID active; with no candidate it returns 1023 and changes nothing.
- R7: An active ID is not presented again until its ID is written to offset 0xB4.
- R8: A read of offset 0x68 returns bit 31 set when a candidate exists and bits[9:0] holding the lowest candidate ID (1023 if none), and it has no side effect.
- R9: A write to offset 0x60 produces, one cycle later, a single-cycle `ipi_out_valid` pulse with `ipi_out_id` = `bus_wdata[3:0]` and `ipi_out_mask` = `bus_wdata[8 +: NUM_CPU]`.
- R10: A software interrupt is latched when any broadcast slot is valid with this CPU's bit set in its mask. It stays pending until it is acknowledged. A new latch in the same cycle as its acknowledge wins.
- R11: Private and shared requests are not latched: a line that drops before acknowledge is no longer presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| priv_req | input | 16 | Private request levels (IDs 16..31) |
| shared_req | input | NUM_SHARED | Routed shared request levels (IDs 32 and up) |
| ipi_in_valid | input | NUM_CPU | Broadcast slot valid, one per sending core |
| ipi_in_mask | input | NUM_CPU*NUM_CPU | Target mask per slot |
| ipi_in_id | input | NUM_CPU*4 | Software interrupt number per slot |
| ipi_out_valid | output | 1 | This core's broadcast pulse |
| ipi_out_mask | output | NUM_CPU | Target mask of this core's broadcast |
| ipi_out_id | output | 4 | Software interrupt number of this core's broadcast |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
A wrong enable or active bit shows up on `irq_out` one cycle after the state is wrong. It also changes the next ready or highest-pending read, so comparing the block against a cycle-accurate model every cycle exposes it at once. A lost or stuck software latch becomes visible only when an acknowledge is attempted, so the directed tests acknowledge every software interrupt that the bench expects and then read the ready register again. An acknowledge and a new latch are made to land in the same cycle to expose which of the two wins. A random phase mixes broadcasts, level changes, completions and writes of out-of-range IDs, so that priority and aliasing faults reach the ports within a few cycles.

// File: rtl/pcif_pkg.sv
package pcif_pkg;
  localparam int ID_W    = 10;
  localparam int SW_N    = 16;
  localparam int PRIV_N  = 16;
  localparam int SWID_W  = 4;
  localparam logic [ID_W-1:0] NO_ID = 10'd1023;

  typedef enum logic [7:0] {
    OFS_CTL = 8'h00,
    OFS_SIG = 8'h60,
    OFS_HPP = 8'h68,
    OFS_RDY = 8'h6C,
    OFS_SET = 8'hA0,
    OFS_CLR = 8'hA4,
    OFS_EOI = 8'hB4
  } ofs_e;
endpackage

// File: rtl/pcif_sw_latch.sv
module pcif_sw_latch
  import pcif_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CPU_ID  = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CPU-1:0]          slot_valid,
  input  logic [NUM_CPU*NUM_CPU-1:0]  slot_mask,
  input  logic [NUM_CPU*SWID_W-1:0]   slot_id,
  input  logic                        clr_valid,
  input  logic [SWID_W-1:0]           clr_id,
  output logic [SW_N-1:0]             sw_pend
);
  logic [SW_N-1:0] set_vec;
  logic [SW_N-1:0] pend_d;
  logic            unused_mask;

  assign unused_mask = ^slot_mask;

  always_comb begin
    set_vec = '0;
    for (int s = 0; s < NUM_CPU; s++) begin
      if (slot_valid[s] && slot_mask[s*NUM_CPU+CPU_ID])
        set_vec[slot_id[s*SWID_W +: SWID_W]] = 1'b1;
    end
  end

  always_comb begin
    pend_d = sw_pend;
    if (clr_valid) pend_d[clr_id] = 1'b0;
    pend_d = pend_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_pend <= '0;
    else        sw_pend <= pend_d;
  end

  // R10: a latched request survives, even against a same-cycle acknowledge
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((sw_pend & $past(set_vec)) == $past(set_vec)));
  // R10: acknowledge without a new latch clears the bit
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !set_vec[clr_id]) |=> !sw_pend[$past(clr_id)]);
endmodule

// File: rtl/pcif_pick.sv
module pcif_pick
  import pcif_pkg::*;
#(
  parameter int N = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    cand,
  output logic            any,
  output logic [ID_W-1:0] id
);
  always_comb begin
    any = 1'b0;
    id  = NO_ID;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        any = 1'b1;
        id  = ID_W'(i);
      end
    end
  end

  // R6: the chosen ID is a candidate and no lower ID is one
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (cand[id[$clog2(N)-1:0]] && ((cand & ~({N{1'b1}} << id)) == '0)));
  // R8: no candidate reports the empty code
  a_r8_empty_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> (id == NO_ID));
endmodule

// File: rtl/pcif_state.sv
module pcif_state
  import pcif_pkg::*;
#(
  parameter int N = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_v,
  input  logic            clr_v,
  input  logic            eoi_v,
  input  logic [ID_W-1:0] wr_id,
  input  logic            ack_v,
  input  logic [ID_W-1:0] ack_id,
  output logic [N-1:0]    en,
  output logic [N-1:0]    act
);
  localparam int IW = $clog2(N);
  localparam logic [ID_W-1:0] N_ID = ID_W'(N);

  logic          id_ok;
  logic [IW-1:0] wix;
  logic [IW-1:0] aix;
  logic [N-1:0]  en_d;
  logic [N-1:0]  act_d;
  logic          unused_ack;

  assign id_ok      = (wr_id < N_ID);
  assign wix        = wr_id[IW-1:0];
  assign aix        = ack_id[IW-1:0];
  assign unused_ack = ^ack_id;

  always_comb begin
    en_d  = en;
    act_d = act;
    if (set_v && id_ok) en_d[wix]  = 1'b1;
    if (clr_v && id_ok) en_d[wix]  = 1'b0;
    if (eoi_v && id_ok) act_d[wix] = 1'b0;
    if (ack_v)          act_d[aix] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= '0;
      act <= '0;
    end else begin
      en  <= en_d;
      act <= act_d;
    end
  end

  // R6: acknowledged ID is active in the following cycle
  a_r6_ack_marks_active: assert property (@(posedge clk) disable iff (!rst_n)
    ack_v |=> act[$past(aix)]);
  // R7: completion clears the active bit unless re-acknowledged at once
  a_r7_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_v && id_ok && !(ack_v && aix == wix)) |=> !act[$past(wix)]);
  // R3: out-of-range IDs leave the enables untouched
  a_r3_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_v || clr_v) && !id_ok) |=> (en == $past(en)));
endmodule

// File: rtl/percpu_intc_if.sv
module percpu_intc_if
  import pcif_pkg::*;
#(
  parameter int NUM_CPU    = 4,
  parameter int CPU_ID     = 1,
  parameter int NUM_SHARED = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [7:0]                    bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [15:0]                   priv_req,
  input  logic [NUM_SHARED-1:0]         shared_req,
  input  logic [NUM_CPU-1:0]            ipi_in_valid,
  input  logic [NUM_CPU*NUM_CPU-1:0]    ipi_in_mask,
  input  logic [NUM_CPU*4-1:0]          ipi_in_id,
  output logic                          ipi_out_valid,
  output logic [NUM_CPU-1:0]            ipi_out_mask,
  output logic [3:0]                    ipi_out_id,
  output logic                          irq_out
);
  localparam int NUM_IDS = SW_N + PRIV_N + NUM_SHARED;
  localparam int IW      = $clog2(NUM_IDS);

  logic                 ctl_q, ctl_d;
  logic                 irq_d;
  logic [31:0]          rdata_d;
  logic                 ipv_d;
  logic [NUM_CPU-1:0]   ipm_d;
  logic [3:0]           ipid_d;
  logic                 wr_ctl, wr_sig, wr_set, wr_clr, wr_eoi;
  logic                 rd_ctl, rd_hpp, rd_rdy;
  logic [ID_W-1:0]      wr_id;
  logic [SW_N-1:0]      sw_pend;
  logic [NUM_IDS-1:0]   pending, en, act, cand;
  logic                 pick_any;
  logic [ID_W-1:0]      pick_id;
  logic                 ack_v;
  logic                 unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign wr_id  = bus_wdata[ID_W-1:0];
  assign wr_ctl = bus_wr && (bus_addr == OFS_CTL);
  assign wr_sig = bus_wr && (bus_addr == OFS_SIG);
  assign wr_set = bus_wr && (bus_addr == OFS_SET);
  assign wr_clr = bus_wr && (bus_addr == OFS_CLR);
  assign wr_eoi = bus_wr && (bus_addr == OFS_EOI);
  assign rd_ctl = bus_rd && (bus_addr == OFS_CTL);
  assign rd_hpp = bus_rd && (bus_addr == OFS_HPP);
  assign rd_rdy = bus_rd && (bus_addr == OFS_RDY);

  assign pending = {shared_req, priv_req, sw_pend};
  assign cand    = pending & en & ~act & {NUM_IDS{ctl_q}};
  assign ack_v   = rd_rdy && pick_any;

  pcif_sw_latch #(.NUM_CPU(NUM_CPU), .CPU_ID(CPU_ID)) u_sw (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_valid (ipi_in_valid),
    .slot_mask  (ipi_in_mask),
    .slot_id    (ipi_in_id),
    .clr_valid  (ack_v && (pick_id < ID_W'(SW_N))),
    .clr_id     (pick_id[3:0]),
    .sw_pend    (sw_pend)
  );

  pcif_pick #(.N(NUM_IDS)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .cand  (cand),
    .any   (pick_any),
    .id    (pick_id)
  );

  pcif_state #(.N(NUM_IDS)) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_v  (wr_set),
    .clr_v  (wr_clr),
    .eoi_v  (wr_eoi),
    .wr_id  (wr_id),
    .ack_v  (ack_v),
    .ack_id (pick_id),
    .en     (en),
    .act    (act)
  );

  always_comb begin
    ctl_d   = wr_ctl ? bus_wdata[0] : ctl_q;
    irq_d   = pick_any;
    ipv_d   = wr_sig;
    ipm_d   = wr_sig ? bus_wdata[8 +: NUM_CPU] : ipi_out_mask;
    ipid_d  = wr_sig ? bus_wdata[3:0] : ipi_out_id;
    rdata_d = bus_rdata;
    if (bus_rd) begin
      rdata_d = '0;
      if (rd_ctl) rdata_d = {31'b0, ctl_q};
      if (rd_hpp) rdata_d = {pick_any, 21'b0, pick_id};
      if (rd_rdy) rdata_d = {22'b0, pick_id};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q         <= 1'b0;
      irq_out       <= 1'b0;
      bus_rdata     <= '0;
      ipi_out_valid <= 1'b0;
      ipi_out_mask  <= '0;
      ipi_out_id    <= '0;
    end else begin
      ctl_q         <= ctl_d;
      irq_out       <= irq_d;
      bus_rdata     <= rdata_d;
      ipi_out_valid <= ipv_d;
      ipi_out_mask  <= ipm_d;
      ipi_out_id    <= ipid_d;
    end
  end

  // R4: a disabled interface keeps the line low
  a_r4_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q && !$past(ctl_q)) |-> !irq_out);
  // R9: a broadcast pulse only follows a signal-register write
  a_r9_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_out_valid |-> $past(bus_wr && bus_addr == OFS_SIG));
  // R7: the acknowledged ID is never one that is already active
  a_r7_not_active: assert property (@(posedge clk) disable iff (!rst_n)
    ack_v |-> (!act[pick_id[IW-1:0]] && en[pick_id[IW-1:0]]));
endmodule

// File: tb/percpu_intc_if_bench.sv
module percpu_intc_if_bench;
  localparam int NC = 4;
  localparam int ME = 1;
  localparam int NS = 32;
  localparam int NI = 32 + NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] priv_req = '0;
  logic [NS-1:0] shared_req = '0;
  logic [NC-1:0] ipi_in_valid;
  logic [NC*NC-1:0] ipi_in_mask;
  logic [NC*4-1:0] ipi_in_id;
  logic ipi_out_valid;
  logic [NC-1:0] ipi_out_mask;
  logic [3:0] ipi_out_id;
  logic irq_out;

  logic [NC-1:0] ext_v = '0;
  logic [NC-1:0] ext_m [NC];
  logic [3:0]    ext_id [NC];

  int n_tests = 0, n_fail = 0;
  logic [31:0] rd_val;

  always #10 clk = ~clk;

  always_comb begin
    for (int s = 0; s < NC; s++) begin
      if (s == ME) begin
        ipi_in_valid[s] = ipi_out_valid;
        ipi_in_mask[s*NC +: NC] = ipi_out_mask;
        ipi_in_id[s*4 +: 4] = ipi_out_id;
      end else begin
        ipi_in_valid[s] = ext_v[s];
        ipi_in_mask[s*NC +: NC] = ext_m[s];
        ipi_in_id[s*4 +: 4] = ext_id[s];
      end
    end
  end

  percpu_intc_if #(.NUM_CPU(NC), .CPU_ID(ME), .NUM_SHARED(NS)) u_percpu_intc_if (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .priv_req(priv_req), .shared_req(shared_req),
    .ipi_in_valid(ipi_in_valid), .ipi_in_mask(ipi_in_mask), .ipi_in_id(ipi_in_id),
    .ipi_out_valid(ipi_out_valid), .ipi_out_mask(ipi_out_mask),
    .ipi_out_id(ipi_out_id), .irq_out(irq_out)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_sw;
  logic [NI-1:0] m_en, m_act;
  logic m_ctl, m_irq, m_ipv;
  logic [31:0] m_rdata;
  logic [NC-1:0] m_ipm;
  logic [3:0] m_ipid;
  int mp;

  function automatic int m_pick();
    for (int i = 0; i < NI; i++) begin
      logic p;
      if (i < 16) p = m_sw[i];
      else if (i < 32) p = priv_req[i-16];
      else p = shared_req[i-32];
      if (m_ctl && m_en[i] && !m_act[i] && p) return i;
    end
    return 1023;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sw <= '0; m_en <= '0; m_act <= '0; m_ctl <= 1'b0; m_irq <= 1'b0;
      m_ipv <= 1'b0; m_rdata <= '0; m_ipm <= '0; m_ipid <= '0;
    end else begin
      mp = m_pick();
      m_irq <= (mp != 1023);
      m_ipv <= 1'b0;
      if (bus_rd) begin
        case (bus_addr)
          8'h00: m_rdata <= {31'b0, m_ctl};
          8'h68: m_rdata <= {(mp != 1023), 21'b0, 10'(mp)};
          8'h6C: begin
            m_rdata <= 32'(mp);
            if (mp != 1023) begin
              m_act[mp] <= 1'b1;
              if (mp < 16) m_sw[mp] <= 1'b0;
            end
          end
          default: m_rdata <= '0;
        endcase
      end
      if (bus_wr) begin
        case (bus_addr)
          8'h00: m_ctl <= bus_wdata[0];
          8'hA0: if (bus_wdata[9:0] < NI) m_en[bus_wdata[9:0]] <= 1'b1;
          8'hA4: if (bus_wdata[9:0] < NI) m_en[bus_wdata[9:0]] <= 1'b0;
          8'hB4: if (bus_wdata[9:0] < NI) m_act[bus_wdata[9:0]] <= 1'b0;
          8'h60: begin m_ipv <= 1'b1; m_ipm <= bus_wdata[8 +: NC]; m_ipid <= bus_wdata[3:0]; end
          default: ;
        endcase
      end
      for (int s = 0; s < NC; s++) begin
        if (s == ME) begin
          if (m_ipv && m_ipm[ME]) m_sw[m_ipid] <= 1'b1;
        end else if (ext_v[s] && ext_m[s][ME]) m_sw[ext_id[s]] <= 1'b1;
      end
    end
  end

  // cycle-by-cycle comparison of every output (R5 line, R9 broadcast, R6/R8 read data)
  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (irq_out !== m_irq || ipi_out_valid !== m_ipv || bus_rdata !== m_rdata ||
          (m_ipv && (ipi_out_mask !== m_ipm || ipi_out_id !== m_ipid))) begin
        n_fail++;
        $display("FAIL R5/R9/R6 model: irq=%0b/%0b ipv=%0b/%0b rdata=%h/%h (actual/expected)",
                 irq_out, m_irq, ipi_out_valid, m_ipv, bus_rdata, m_rdata);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_tests++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NC; s++) begin ext_m[s] = '0; ext_id[s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    check("R1 irq after reset", 32'(irq_out), 0);
    rd(8'h6C, rd_val); check("R1 ready empty", rd_val, 32'd1023);
    rd(8'h68, rd_val); check("R8 hpp empty", rd_val, 32'h0000_03FF);
    rd(8'h00, rd_val); check("R1 ctl reset", rd_val, 0);

    wr(8'h00, 1);
    rd(8'h00, rd_val); check("R4 ctl readback", rd_val, 1);

    shared_req[5] = 1'b1; idle(2);
    check("R3 not enabled", 32'(irq_out), 0);
    wr(8'hA0, 37); idle(1);
    check("R5 irq raised", 32'(irq_out), 1);
    rd(8'h68, rd_val); check("R8 hpp shared", rd_val, 32'h8000_0025);
    priv_req[3] = 1'b1; wr(8'hA0, 19);
    rd(8'h6C, rd_val); check("R2 R6 lowest private", rd_val, 19);
    rd(8'h6C, rd_val); check("R6 next shared", rd_val, 37);
    rd(8'h6C, rd_val); check("R7 both active", rd_val, 1023);
    idle(1); check("R7 irq low while active", 32'(irq_out), 0);
    wr(8'hB4, 19);
    rd(8'h68, rd_val); check("R7 back after eoi", rd_val, 32'h8000_0013);
    priv_req[3] = 1'b0; wr(8'hB4, 37); shared_req[5] = 1'b0;
    rd(8'h6C, rd_val); check("R11 level dropped", rd_val, 1023);

    shared_req[5] = 1'b1; wr(8'h00, 0); idle(2);
    check("R4 disabled irq", 32'(irq_out), 0);
    rd(8'h6C, rd_val); check("R4 disabled ready", rd_val, 1023);
    wr(8'h00, 1); idle(1);
    check("R4 re-enabled irq", 32'(irq_out), 1);
    wr(8'hA4, 37); idle(1);
    check("R3 disabled id", 32'(irq_out), 0);
    shared_req[5] = 1'b0;

    // out-of-range enable must not alias onto ID 5
    wr(8'hA0, 64 + 5);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h60; bus_wdata = (32'h2 << 8) | 5;
    @(negedge clk); bus_wr = 1'b0;
    check("R9 pulse valid", 32'(ipi_out_valid), 1);
    check("R9 pulse id", 32'(ipi_out_id), 5);
    check("R9 pulse mask", 32'(ipi_out_mask), 2);
    @(negedge clk); check("R9 single cycle", 32'(ipi_out_valid), 0);
    rd(8'h6C, rd_val); check("R3 no alias", rd_val, 1023);
    wr(8'hA0, 5);
    rd(8'h6C, rd_val); check("R10 sw latched", rd_val, 5);
    wr(8'hB4, 5);
    rd(8'h6C, rd_val); check("R10 cleared by ack", rd_val, 1023);

    // external slots: one targets this CPU, one does not
    wr(8'hA0, 2); wr(8'hA0, 3);
    @(negedge clk);
    ext_v[0] = 1'b1; ext_m[0] = 4'b0010; ext_id[0] = 2;
    ext_v[2] = 1'b1; ext_m[2] = 4'b1101; ext_id[2] = 3;
    @(negedge clk); ext_v = '0;
    rd(8'h6C, rd_val); check("R10 external latched", rd_val, 2);
    rd(8'h6C, rd_val); check("R10 not targeted", rd_val, 1023);
    wr(8'hB4, 2);

    // latch in the same cycle as acknowledge
    wr(8'hA0, 9);
    @(negedge clk); ext_v[0] = 1'b1; ext_m[0] = 4'b0010; ext_id[0] = 9;
    @(negedge clk); ext_v[0] = 1'b0;
    @(negedge clk); bus_rd = 1'b1; bus_addr = 8'h6C;
    ext_v[3] = 1'b1; ext_m[3] = 4'b0010; ext_id[3] = 9;
    @(negedge clk); bus_rd = 1'b0; ext_v[3] = 1'b0;
    check("R10 ack value", bus_rdata, 9);
    wr(8'hB4, 9);
    rd(8'h6C, rd_val); check("R10 set wins", rd_val, 9);
    wr(8'hB4, 9);

    // random phase against the model
    for (int k = 0; k < 3000; k++) begin
      int op;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; ext_v = '0;
      op = int'($urandom_range(0, 9));
      bus_wdata = $urandom;
      bus_wdata[9:0] = 10'($urandom_range(0, 70));
      case (op)
        0: begin bus_wr = 1'b1; bus_addr = 8'hA0; end
        1: begin bus_wr = 1'b1; bus_addr = 8'hA4; end
        2, 3: begin bus_wr = 1'b1; bus_addr = 8'hB4; end
        4, 5: begin bus_rd = 1'b1; bus_addr = 8'h6C; end
        6: begin bus_rd = 1'b1; bus_addr = ($urandom_range(0, 1) != 0) ? 8'h68 : 8'h00; end
        7: begin bus_wr = 1'b1; bus_addr = 8'h60; end
        8: begin bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata[0] = ($urandom_range(0, 7) != 0); end
        default: begin
          priv_req = priv_req ^ 16'(1 << $urandom_range(0, 15));
          shared_req = shared_req ^ NS'(1 << $urandom_range(0, NS - 1));
          ext_v[0] = 1'b1; ext_m[0] = 4'($urandom); ext_id[0] = 4'($urandom);
        end
      endcase
    end
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0; ext_v = '0;
    idle(4);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule